// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit controller core, together with its status register. Given two operands, a 4-bit operation code and the flags it already holds, it produces an 8-bit result combinationally. When `exec` is high at a rising clock edge, it updates the carry, half-carry, zero and overflow flags as the operation requires. It supports binary add and subtract, with and without carry, decimal adjust, the bitwise operations, complement, four rotates, increment and decrement.

The same register holds two system flags, a power-down flag and a time-out flag. A data write can never change them. Only reset and three event strobes change them: watchdog clear, halt entry and watchdog time-out. Software stores into the status register through `st_we`, and that store reaches only the four arithmetic flags.

Top module: `alu8_status`

## Requirements
- R1: After reset `status` reads 0x00. Bit layout: bit0 carry, bit1 half-carry, bit2 zero, bit3 overflow, bit4 power-down, bit5 time-out. Bits 7:6 always read 0.
- R2: Opcodes are 0 ADD (a+b), 1 ADC (a+b+carry), 2 SUB (a-b), 3 SBC (a-b-!carry). For each of these, `result` is the low 8 bits of the value shown. Carry is set on a carry out of an add, and on a subtract that needs no borrow. Half-carry is set on a carry out of the low nibble, or on no borrow into the low nibble. Overflow is set on a signed overflow. Zero is set when the result is zero.
- R3: Opcode 4 (decimal adjust of a) adds 0x06 when a[3:0]>9 or half-carry is set. It then adds 0x60 when the upper nibble of that sum is >9 or carry is set. Carry becomes 1 if either addition carried out of bit 7, and zero is updated. Half-carry and overflow are kept.
- R4: Opcodes 5 AND, 6 OR, 7 XOR, 8 complement of a, 13 a+1 and 14 a-1 update only the zero flag.
- R5: Opcodes 9 (rotate a left) and 10 (rotate a right) change no flag.
- R6: Opcodes 11 (rotate left through carry) and 12 (rotate right through carry) shift carry into the vacated bit and load the bit shifted out into carry. No other flag changes.
- R7: Opcode 15 passes a to `result` and changes no flag. With `exec` low, no flag changes.
- R8: A status write (`st_we`) loads bits 3:0 from `st_wdata` and takes precedence over `exec`. It never changes bits 5:4.
- R9: Halt sets power-down and clears time-out. Watchdog clear clears both flags. Time-out sets time-out. When events coincide, halt wins over clear for power-down, and time-out wins for the time-out flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| exec | input | 1 | Commit flag updates of the current operation |
| op | input | 4 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| st_we | input | 1 | Data write to status bits 3:0 |
| st_wdata | input | 8 | Write data |
| wdt_clr | input | 1 | Watchdog clear event |
| halt | input | 1 | Halt entry event |
| wdt_to | input | 1 | Watchdog time-out event |
| result | output | 8 | Operation result (combinational) |
| status | output | 8 | Status register |

## Verification
`result` depends combinationally on the operands, the opcode and the flags already held, so the bench checks it in the same cycle, 2 ns after driving the inputs at the falling edge. Flag updates, writes and events all take effect at the next rising edge. The bench therefore checks `status` 2 ns after that edge, against a model it advances exactly once per edge. Random operations, with occasional writes and events mixed in, alternate with directed cases for decimal adjust, borrow and event priority.

// File: rtl/alu8_status.sv
module alu8_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [3:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       st_we,
  input  logic [7:0] st_wdata,
  input  logic       wdt_clr,
  input  logic       halt,
  input  logic       wdt_to,
  output logic [7:0] result,
  output logic [7:0] status
);

  logic c_q, ac_q, z_q, ov_q, pd_q, to_q;
  logic c_n, ac_n, z_n, ov_n;

  logic       is_sub, cin;
  logic [7:0] bx;
  logic [8:0] sum9;
  logic [4:0] lo5;
  logic [7:0] lo7;
  logic [8:0] adj1, adj2;

  assign is_sub = (op == 4'd2) || (op == 4'd3);
  assign bx     = is_sub ? ~b : b;
  assign cin    = (op == 4'd0) ? 1'b0 : (op == 4'd2) ? 1'b1 : c_q;
  assign sum9   = {1'b0, a} + {1'b0, bx} + {8'd0, cin};
  assign lo5    = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'd0, cin};
  assign lo7    = {1'b0, a[6:0]} + {1'b0, bx[6:0]} + {7'd0, cin};
  assign adj1   = {1'b0, a} + ((a[3:0] > 4'd9 || ac_q) ? 9'h006 : 9'h000);
  assign adj2   = {1'b0, adj1[7:0]} + ((adj1[7:4] > 4'd9 || c_q) ? 9'h060 : 9'h000);

  always_comb begin
    result = a;
    c_n = c_q; ac_n = ac_q; z_n = z_q; ov_n = ov_q;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        result = sum9[7:0];
        c_n  = sum9[8];
        ac_n = lo5[4];
        ov_n = lo7[7] ^ sum9[8];
        z_n  = (sum9[7:0] == 8'd0);
      end
      4'd4: begin
        result = adj2[7:0];
        c_n = adj1[8] | adj2[8];
        z_n = (adj2[7:0] == 8'd0);
      end
      4'd5:  begin result = a & b;        z_n = (result == 8'd0); end
      4'd6:  begin result = a | b;        z_n = (result == 8'd0); end
      4'd7:  begin result = a ^ b;        z_n = (result == 8'd0); end
      4'd8:  begin result = ~a;           z_n = (result == 8'd0); end
      4'd9:  result = {a[6:0], a[7]};
      4'd10: result = {a[0], a[7:1]};
      4'd11: begin result = {a[6:0], c_q}; c_n = a[7]; end
      4'd12: begin result = {c_q, a[7:1]}; c_n = a[0]; end
      4'd13: begin result = a + 8'd1;     z_n = (result == 8'd0); end
      4'd14: begin result = a - 8'd1;     z_n = (result == 8'd0); end
      default: result = a;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_q, ac_q, z_q, ov_q, pd_q, to_q} <= '0;
    end else begin
      if (st_we)
        {ov_q, z_q, ac_q, c_q} <= st_wdata[3:0];
      else if (exec)
        {ov_q, z_q, ac_q, c_q} <= {ov_n, z_n, ac_n, c_n};
      if (halt)         pd_q <= 1'b1;
      else if (wdt_clr) pd_q <= 1'b0;
      if (wdt_to)                to_q <= 1'b1;
      else if (halt || wdt_clr)  to_q <= 1'b0;
    end
  end

  assign status = {2'b00, to_q, pd_q, ov_q, z_q, ac_q, c_q};

  // R1
  top_bits_zero_chk: assert property (@(posedge clk) status[7:6] == 2'b00);

  // R8
  write_keeps_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !halt && !wdt_clr && !wdt_to) |=> $stable(status[5:4]));

  // R8
  write_loads_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> status[3:0] == $past(st_wdata[3:0]));

  // R7
  idle_holds_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && !st_we) |=> $stable(status[3:0]));

  // R5
  plain_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !st_we && (op == 4'd9 || op == 4'd10)) |=> $stable(status[3:0]));

  // R9
  halt_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wdt_to) |=> (status[5:4] == 2'b01));

  // R9
  timeout_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to |=> status[5]);

endmodule

// File: tb/alu8_status_tb.sv
module alu8_status_tb;
  logic clk = 0, rst_n = 0;
  logic exec = 0, st_we = 0, wdt_clr = 0, halt = 0, wdt_to = 0;
  logic [3:0] op = 0;
  logic [7:0] a = 0, b = 0, st_wdata = 0;
  logic [7:0] result, status;
  int checks = 0, errors = 0;
  logic [7:0] m_st;

  always #10 clk = ~clk;

  alu8_status u_dut (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .a(a), .b(b),
    .st_we(st_we), .st_wdata(st_wdata), .wdt_clr(wdt_clr), .halt(halt),
    .wdt_to(wdt_to), .result(result), .status(status));

  function automatic logic [11:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic [3:0] f);
    int s, lo, sv, brw, t;
    logic c, ac, z, ov;
    logic [7:0] r;
    c = f[0]; ac = f[1]; z = f[2]; ov = f[3]; r = x;
    case (o)
      0, 1: begin
        t = (o == 1) ? int'(c) : 0;
        s = int'(x) + int'(y) + t; lo = int'(x[3:0]) + int'(y[3:0]) + t;
        sv = int'($signed(x)) + int'($signed(y)) + t;
        r = s[7:0]; c = s > 255; ac = lo > 15; ov = sv > 127 || sv < -128; z = r == 0;
      end
      2, 3: begin
        brw = (o == 3) ? int'(!c) : 0;
        s = int'(x) - int'(y) - brw; sv = int'($signed(x)) - int'($signed(y)) - brw;
        r = s[7:0]; c = int'(x) >= int'(y) + brw;
        ac = int'(x[3:0]) >= int'(y[3:0]) + brw;
        ov = sv > 127 || sv < -128; z = r == 0;
      end
      4: begin
        s = int'(x); t = 0;
        if (x[3:0] > 9 || ac) s = s + 6;
        if (s > 255) t = 1;
        s = s % 256;
        if (s / 16 > 9 || c) s = s + 96;
        if (s > 255) t = 1;
        r = s[7:0]; c = t[0]; z = r == 0;
      end
      5: begin r = x & y; z = r == 0; end
      6: begin r = x | y; z = r == 0; end
      7: begin r = x ^ y; z = r == 0; end
      8: begin r = ~x; z = r == 0; end
      9: r = {x[6:0], x[7]};
      10: r = {x[0], x[7:1]};
      11: begin r = {x[6:0], c}; c = x[7]; end
      12: begin r = {c, x[7:1]}; c = x[0]; end
      13: begin r = x + 1; z = r == 0; end
      14: begin r = x - 1; z = r == 0; end
      default: r = x;
    endcase
    return {r, ov, z, ac, c};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    if (o <= 3) return "R2";
    if (o == 4) return "R3";
    if (o == 9 || o == 10) return "R5";
    if (o == 11 || o == 12) return "R6";
    if (o == 15) return "R7";
    return "R4";
  endfunction

  task automatic step(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                      input logic ex, input logic we, input logic [7:0] wd,
                      input logic cl, input logic hl, input logic to);
    logic [11:0] m;
    @(negedge clk);
    op = o; a = x; b = y; exec = ex; st_we = we; st_wdata = wd;
    wdt_clr = cl; halt = hl; wdt_to = to;
    #2;
    m = model(o, x, y, m_st[3:0]);
    check(req_of(o), result, m[11:4]);
    if (we) m_st[3:0] = wd[3:0];
    else if (ex) m_st[3:0] = m[3:0];
    if (hl) m_st[4] = 1; else if (cl) m_st[4] = 0;
    if (to) m_st[5] = 1; else if (hl || cl) m_st[5] = 0;
    @(posedge clk); #2;
    if (we) check("R8", status, m_st);
    else if (hl || cl || to) check("R9", status, m_st);
    else if (!ex) check("R7", status, m_st);
    else check(req_of(o), status, m_st);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_st = 0;
    repeat (2) @(negedge clk);
    check("R1", status, 8'h00);
    rst_n = 1;
    // R2 borrow: 0x10-0x20 -> 0xF0, no carry
    step(2, 8'h10, 8'h20, 1, 0, 0, 0, 0, 0);
    // R2 add overflow 0x7F+0x01
    step(0, 8'h7F, 8'h01, 1, 0, 0, 0, 0, 0);
    // R3 BCD 15+27 then adjust -> 42
    step(0, 8'h15, 8'h27, 1, 0, 0, 0, 0, 0);
    step(4, 8'h3C, 0, 1, 0, 0, 0, 0, 0);
    step(4, 8'h9A, 0, 1, 0, 0, 0, 0, 0);
    // R6 rotate through carry
    step(11, 8'h80, 0, 1, 0, 0, 0, 0, 0);
    step(12, 8'h01, 0, 1, 0, 0, 0, 0, 0);
    // R4 zero from decrement
    step(14, 8'h01, 0, 1, 0, 0, 0, 0, 0);
    // R8 write all ones, sys bits stay
    step(15, 0, 0, 1, 1, 8'hFF, 0, 0, 0);
    check("R1", {status[7:6], 6'd0}, 8'h00);
    // R9 events and priorities
    step(15, 0, 0, 0, 0, 0, 0, 0, 1);
    step(15, 0, 0, 0, 0, 0, 0, 1, 0);
    step(15, 0, 0, 0, 0, 0, 0, 1, 1);
    step(15, 0, 0, 0, 0, 0, 1, 1, 0);
    step(15, 0, 0, 0, 0, 0, 1, 0, 0);
    step(15, 0, 0, 0, 1, 8'hF0, 0, 1, 0);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0], $urandom, $urandom, r[7:4] != 0, r[11:8] == 0, $urandom,
           r[15:12] == 0, r[19:16] == 1, r[23:20] == 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule